// File: doc/BRIEF.md
# Display Link Two-Wire Target Controller

This block is the target side of the two-wire serial management link that a display sink presents to a video source. It watches the clock and data lines, detects start and stop conditions, and responds to two device addresses. One address reads the sink's capability table, which sits in an external single-port memory. The other reaches an external status and control register file for reads and writes. The block only ever pulls the data line low or lets it go. The open-drain pad is outside the block.

One offset pointer is shared by both targets. A write transfer sets it with its first data byte. Every byte transferred after that advances it by one. A read started with a repeated start continues from wherever the pointer stands. The block also keeps a copy of two bits of the link configuration register: the clock-ratio bit and the scrambler-enable bit. When a write changes either bit, the block emits a one-cycle strobe for that bit, so the transmit path can react.

Both back ends use the same read handshake. The block raises a read strobe with the address on `rd_addr`, and the back end returns the data on the next clock edge and holds it there. The line inputs are sampled with the system clock and pass through a two-flop synchronizer.

Top module: `ddc_target`

## Requirements
- R1: After reset, `sda_oe`, `ratio_upd` and `scramble_upd` are 0, and the held `tmds_ratio` and `scramble_en` outputs are 0.
- R2: An address byte of 0xA0 or 0xA1 (capability table) is acknowledged, and so is 0xA8 or 0xA9 (control registers). Bit 0 of the address byte selects the direction: 1 means read and 0 means write.
- R3: Any other address byte, including the neighbours 0xA2 and 0xB0, gets no acknowledge. The data line then stays released for the rest of the transfer, until the next start.
- R4: The first data byte after a write address is acknowledged and loaded into the offset pointer.
- R5: A read from the capability address returns the memory word at the pointer, most significant bit first. The pointer advances by one after each byte.
- R6: A read that begins with a start followed directly by a read address continues from the current pointer value.
- R7: After the offset byte, each data byte written to the control address is acknowledged. Each one gives exactly one register write pulse, at consecutive offsets.
- R8: Data bytes written to the capability address are acknowledged and produce no register write. They still advance the pointer.
- R9: When the source answers a read byte with a not-acknowledge, the block releases the data line and ignores all clocks until the next start.
- R10: A register write to offset 0x20 updates `tmds_ratio` from data bit 1 and `scramble_en` from data bit 0. A one-cycle strobe fires for each of those bits whose value changes, and both strobes fire in the same cycle when both bits change.
- R11: `sda_oe` changes only while the synchronized clock line is low.
- R12: A read from the control address returns the register read port data at the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| rd_addr | output | AW | Offset pointer, used as the read address for both back ends |
| mem_rd | output | 1 | Capability memory read strobe |
| mem_rdata | input | 8 | Capability memory data, valid one cycle after `mem_rd` |
| reg_rd | output | 1 | Control register read strobe |
| reg_rdata | input | 8 | Control register data, valid one cycle after `reg_rd` |
| reg_wr | output | 1 | Control register write pulse |
| reg_waddr | output | AW | Control register write offset |
| reg_wdata | output | 8 | Control register write data |
| tmds_ratio | output | 1 | Held clock-ratio bit |
| scramble_en | output | 1 | Held scrambler-enable bit |
| ratio_upd | output | 1 | Pulse when the clock-ratio bit changes |
| scramble_upd | output | 1 | Pulse when the scrambler-enable bit changes |

## Verification
Two updates can land on the same cycle: the clock-ratio strobe and the scrambler-enable strobe. When a single write changes both bits, both strobes must fire together. The bench provokes this by writing 0x03 to offset 0x20 while both bits are still 0. A monitor then counts, at every falling clock edge, the cycles in which both strobes are high, and that count must be exactly one. A later write of 0x02 is expected to raise only the scrambler strobe, which confirms that the two strobes are decided separately.

// File: rtl/ddc_pkg.sv
package ddc_pkg;
    localparam int DW = 8;
    localparam int BCW = $clog2(DW);
    localparam logic [BCW-1:0] LAST_BIT = BCW'(DW - 1);
    localparam int RATIO_BIT = 1;
    localparam int SCR_BIT = 0;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK
    } link_st_t;

    typedef enum logic [1:0] {TGT_NONE, TGT_CAP, TGT_CTRL} tgt_t;

    function automatic tgt_t dev_decode(input logic [DW-2:0] dev,
                                        input logic [DW-2:0] cap_dev,
                                        input logic [DW-2:0] ctrl_dev);
        if (dev == cap_dev) return TGT_CAP;
        if (dev == ctrl_dev) return TGT_CTRL;
        return TGT_NONE;
    endfunction
endpackage

// File: rtl/ddc_sync.sv
module ddc_sync #(
    parameter int W = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    localparam int PW = (STAGES + 1) * W;
    logic [PW-1:0] pipe;
    logic [W-1:0] prev;

    always_ff @(posedge clk) begin
        if (rst) pipe <= '1;
        else     pipe <= {pipe[PW-W-1:0], din};
    end

    assign lvl  = pipe[(STAGES-1)*W +: W];
    assign prev = pipe[STAGES*W +: W];
    assign rise = lvl & ~prev;
    assign fall = ~lvl & prev;
endmodule

// File: rtl/ddc_cfg_track.sv
module ddc_cfg_track #(
    parameter int AW = 8,
    parameter logic [AW-1:0] CFG_OFFSET = 8'h20
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [AW-1:0] waddr,
    input  logic          ratio_in,
    input  logic          scr_in,
    output logic          ratio,
    output logic          scr,
    output logic          ratio_upd,
    output logic          scr_upd
);
    logic hit;
    assign hit = wr && (waddr == CFG_OFFSET);

    always_ff @(posedge clk) begin
        if (rst) begin
            ratio <= 1'b0;
            scr <= 1'b0;
            ratio_upd <= 1'b0;
            scr_upd <= 1'b0;
        end else begin
            ratio_upd <= hit && (ratio_in != ratio);
            scr_upd <= hit && (scr_in != scr);
            if (hit) begin
                ratio <= ratio_in;
                scr <= scr_in;
            end
        end
    end

    assert_ratio_strobe_R10: assert property (@(posedge clk) disable iff (rst)
        ratio_upd |-> (ratio != $past(ratio)));
    assert_scr_strobe_R10: assert property (@(posedge clk) disable iff (rst)
        scr_upd |-> $past(wr));
endmodule

// File: rtl/ddc_link_fsm.sv
module ddc_link_fsm
    import ddc_pkg::*;
#(
    parameter int AW = 8,
    parameter logic [DW-2:0] CAP_DEV = 7'h50,
    parameter logic [DW-2:0] CTRL_DEV = 7'h54
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          scl_lvl,
    input  logic          sda_lvl,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_ev,
    input  logic          stop_ev,
    output logic          sda_oe,
    output logic [AW-1:0] rd_addr,
    output logic          mem_rd,
    output logic          reg_rd,
    input  logic [DW-1:0] mem_rdata,
    input  logic [DW-1:0] reg_rdata,
    output logic          reg_wr,
    output logic [AW-1:0] reg_waddr,
    output logic [DW-1:0] reg_wdata
);
    link_st_t st;
    tgt_t tgt, dec;
    logic dir_rd, first, byte_full, nack, load_pend;
    logic [BCW-1:0] bitcnt;
    logic [DW-1:0] shreg, fetched;
    logic [AW-1:0] ptr;

    assign rd_addr = ptr;
    assign dec = dev_decode(shreg[DW-1:1], CAP_DEV, CTRL_DEV);
    assign fetched = (tgt == TGT_CAP) ? mem_rdata : reg_rdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_IDLE;
            tgt <= TGT_NONE;
            dir_rd <= 1'b0;
            first <= 1'b0;
            byte_full <= 1'b0;
            nack <= 1'b0;
            load_pend <= 1'b0;
            bitcnt <= '0;
            shreg <= '0;
            ptr <= '0;
            sda_oe <= 1'b0;
            mem_rd <= 1'b0;
            reg_rd <= 1'b0;
            reg_wr <= 1'b0;
            reg_waddr <= '0;
            reg_wdata <= '0;
        end else begin
            mem_rd <= 1'b0;
            reg_rd <= 1'b0;
            reg_wr <= 1'b0;
            load_pend <= mem_rd | reg_rd;
            if (start_ev) begin
                st <= ST_ADDR;
                bitcnt <= '0;
                byte_full <= 1'b0;
                sda_oe <= 1'b0;
            end else if (stop_ev) begin
                st <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                unique case (st)
                    ST_ADDR, ST_WR: begin
                        if (scl_rise) begin
                            shreg <= {shreg[DW-2:0], sda_lvl};
                            bitcnt <= bitcnt + 1'b1;
                            if (bitcnt == LAST_BIT) byte_full <= 1'b1;
                        end else if (scl_fall && byte_full) begin
                            byte_full <= 1'b0;
                            if (st == ST_ADDR) begin
                                if (dec == TGT_NONE) begin
                                    st <= ST_IDLE;
                                end else begin
                                    tgt <= dec;
                                    dir_rd <= shreg[0];
                                    first <= ~shreg[0];
                                    sda_oe <= 1'b1;
                                    st <= ST_ADDR_ACK;
                                end
                            end else begin
                                sda_oe <= 1'b1;
                                st <= ST_WR_ACK;
                                if (first) begin
                                    ptr <= AW'(shreg);
                                    first <= 1'b0;
                                end else begin
                                    ptr <= ptr + 1'b1;
                                    if (tgt == TGT_CTRL) begin
                                        reg_wr <= 1'b1;
                                        reg_waddr <= ptr;
                                        reg_wdata <= shreg;
                                    end
                                end
                            end
                        end
                    end
                    ST_ADDR_ACK: if (scl_fall) begin
                        sda_oe <= 1'b0;
                        bitcnt <= '0;
                        if (dir_rd) begin
                            st <= ST_RD;
                            mem_rd <= (tgt == TGT_CAP);
                            reg_rd <= (tgt == TGT_CTRL);
                        end else begin
                            st <= ST_WR;
                        end
                    end
                    ST_WR_ACK: if (scl_fall) begin
                        sda_oe <= 1'b0;
                        st <= ST_WR;
                    end
                    ST_RD: if (scl_fall) begin
                        if (bitcnt == LAST_BIT) begin
                            sda_oe <= 1'b0;
                            st <= ST_RD_ACK;
                            ptr <= ptr + 1'b1;
                        end else begin
                            shreg <= {shreg[DW-2:0], 1'b0};
                            sda_oe <= ~shreg[DW-2];
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) nack <= sda_lvl;
                        if (scl_fall) begin
                            if (nack) begin
                                st <= ST_IDLE;
                            end else begin
                                st <= ST_RD;
                                bitcnt <= '0;
                                mem_rd <= (tgt == TGT_CAP);
                                reg_rd <= (tgt == TGT_CTRL);
                            end
                        end
                    end
                    default: ;
                endcase
            end
            if (load_pend) begin
                shreg <= fetched;
                sda_oe <= ~fetched[DW-1];
            end
        end
    end

    assert_oe_scl_low_R11: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !$past(scl_lvl));
    assert_wr_ctrl_only_R8: assert property (@(posedge clk) disable iff (rst)
        reg_wr |-> (tgt == TGT_CTRL));
    assert_single_fetch_R12: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_rd, reg_rd}));
endmodule

// File: rtl/ddc_target.sv
module ddc_target
    import ddc_pkg::*;
#(
    parameter int AW = 8,
    parameter int SYNC_STAGES = 2,
    parameter logic [DW-2:0] CAP_DEV = 7'h50,
    parameter logic [DW-2:0] CTRL_DEV = 7'h54,
    parameter logic [AW-1:0] CFG_OFFSET = 8'h20
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          scl_in,
    input  logic          sda_in,
    output logic          sda_oe,
    output logic [AW-1:0] rd_addr,
    output logic          mem_rd,
    input  logic [DW-1:0] mem_rdata,
    output logic          reg_rd,
    input  logic [DW-1:0] reg_rdata,
    output logic          reg_wr,
    output logic [AW-1:0] reg_waddr,
    output logic [DW-1:0] reg_wdata,
    output logic          tmds_ratio,
    output logic          scramble_en,
    output logic          ratio_upd,
    output logic          scramble_upd
);
    logic [1:0] lvl, rise, fall;
    logic start_ev, stop_ev;

    ddc_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .din({scl_in, sda_in}),
        .lvl(lvl), .rise(rise), .fall(fall)
    );

    assign start_ev = fall[0] & lvl[1];
    assign stop_ev  = rise[0] & lvl[1];

    ddc_link_fsm #(.AW(AW), .CAP_DEV(CAP_DEV), .CTRL_DEV(CTRL_DEV)) u_fsm (
        .clk(clk), .rst(rst),
        .scl_lvl(lvl[1]), .sda_lvl(lvl[0]),
        .scl_rise(rise[1]), .scl_fall(fall[1]),
        .start_ev(start_ev), .stop_ev(stop_ev),
        .sda_oe(sda_oe), .rd_addr(rd_addr),
        .mem_rd(mem_rd), .reg_rd(reg_rd),
        .mem_rdata(mem_rdata), .reg_rdata(reg_rdata),
        .reg_wr(reg_wr), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata)
    );

    ddc_cfg_track #(.AW(AW), .CFG_OFFSET(CFG_OFFSET)) u_cfg (
        .clk(clk), .rst(rst), .wr(reg_wr), .waddr(reg_waddr),
        .ratio_in(reg_wdata[RATIO_BIT]), .scr_in(reg_wdata[SCR_BIT]),
        .ratio(tmds_ratio), .scr(scramble_en),
        .ratio_upd(ratio_upd), .scr_upd(scramble_upd)
    );
endmodule

// File: tb/sim_ddc_target.sv
module sim_ddc_target;
    localparam int HB = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic scl_drv = 1'b1, sda_drv = 1'b1;
    logic sda_oe, sda_line;
    logic [7:0] rd_addr, mem_q, reg_q, reg_waddr, reg_wdata;
    logic mem_rd, reg_rd, reg_wr, tmds_ratio, scramble_en, ratio_upd, scramble_upd;
    logic [7:0] rf [0:255];

    assign sda_line = sda_drv & ~sda_oe;

    ddc_target u0 (
        .clk(clk), .rst(rst), .scl_in(scl_drv), .sda_in(sda_line), .sda_oe(sda_oe),
        .rd_addr(rd_addr), .mem_rd(mem_rd), .mem_rdata(mem_q),
        .reg_rd(reg_rd), .reg_rdata(reg_q),
        .reg_wr(reg_wr), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
        .tmds_ratio(tmds_ratio), .scramble_en(scramble_en),
        .ratio_upd(ratio_upd), .scramble_upd(scramble_upd)
    );

    function automatic logic [7:0] cap_f(input logic [7:0] a);
        return a ^ 8'hC5;
    endfunction

    always @(posedge clk) begin
        if (mem_rd) mem_q <= cap_f(rd_addr);
        if (reg_wr) rf[reg_waddr] <= reg_wdata;
        if (reg_rd) reg_q <= rf[rd_addr];
    end

    int checks = 0, errors = 0;
    int wr_cnt = 0, ratio_cnt = 0, scr_cnt = 0, both_cnt = 0, viol = 0;
    logic [7:0] log_a [0:15];
    logic [7:0] log_d [0:15];
    logic prev_oe = 1'b0, prev_scl = 1'b1;
    logic done = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (reg_wr) begin
                log_a[wr_cnt[3:0]] = reg_waddr;
                log_d[wr_cnt[3:0]] = reg_wdata;
                wr_cnt++;
            end
            if (ratio_upd) ratio_cnt++;
            if (scramble_upd) scr_cnt++;
            if (ratio_upd && scramble_upd) both_cnt++;
            if (sda_oe != prev_oe && (scl_drv || prev_scl)) viol++;
        end
        prev_oe = sda_oe;
        prev_scl = scl_drv;
    end

    task automatic hw(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_drv = 1'b1; hw(HB);
        scl_drv = 1'b1; hw(HB);
        sda_drv = 1'b0; hw(HB);
        scl_drv = 1'b0; hw(HB);
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; hw(HB);
        scl_drv = 1'b1; hw(HB);
        sda_drv = 1'b1; hw(HB);
    endtask

    task automatic clock_bit(input logic b, output logic s);
        sda_drv = b; hw(HB);
        scl_drv = 1'b1; hw(HB / 2);
        s = sda_line; hw(HB / 2);
        scl_drv = 1'b0;
    endtask

    task automatic put_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
        clock_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic get_byte(input logic mack, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clock_bit(1'b1, s);
            d[i] = s;
        end
        clock_bit(~mack, s);
    endtask

    task automatic t_reset();
        chk("R1 sda_oe", sda_oe, 0);
        chk("R1 tmds_ratio", tmds_ratio, 0);
        chk("R1 scramble_en", scramble_en, 0);
        chk("R1 strobes", {ratio_upd, scramble_upd}, 0);
    endtask

    task automatic t_cap_read();
        logic a; logic [7:0] d;
        bus_start();
        put_byte(8'hA0, a); chk("R2 ack A0", a, 1);
        put_byte(8'h10, a); chk("R4 ack offset", a, 1);
        bus_start();
        put_byte(8'hA1, a); chk("R2 ack A1", a, 1);
        get_byte(1'b1, d); chk("R5 byte0", d, cap_f(8'h10));
        get_byte(1'b1, d); chk("R5 byte1", d, cap_f(8'h11));
        get_byte(1'b0, d); chk("R5 byte2", d, cap_f(8'h12));
        get_byte(1'b0, d); chk("R9 released after nack", d, 8'hFF);
        bus_stop();
    endtask

    task automatic t_continue();
        logic a; logic [7:0] d;
        bus_start();
        put_byte(8'hA1, a); chk("R6 ack", a, 1);
        get_byte(1'b0, d); chk("R6 continued offset", d, cap_f(8'h13));
        bus_stop();
    endtask

    task automatic t_bad_addr();
        logic a; logic [7:0] d;
        bus_start();
        put_byte(8'hB0, a); chk("R3 nack B0", a, 0);
        put_byte(8'h00, a); chk("R3 stays idle ack", a, 0);
        get_byte(1'b0, d); chk("R3 line released", d, 8'hFF);
        bus_stop();
        bus_start();
        put_byte(8'hA2, a); chk("R3 nack A2", a, 0);
        bus_stop();
    endtask

    task automatic t_ctrl_write();
        logic a;
        int base = wr_cnt;
        bus_start();
        put_byte(8'hA8, a); chk("R2 ack A8", a, 1);
        put_byte(8'h1E, a); chk("R4 ack offset", a, 1);
        put_byte(8'h11, a); chk("R7 ack data", a, 1);
        put_byte(8'h22, a); chk("R7 ack data", a, 1);
        put_byte(8'h03, a); chk("R7 ack data", a, 1);
        bus_stop(); hw(5);
        chk("R7 write count", wr_cnt - base, 3);
        chk("R7 addr0", log_a[base[3:0]], 8'h1E);
        chk("R7 addr2", log_a[4'(base + 2)], 8'h20);
        chk("R7 data1", log_d[4'(base + 1)], 8'h22);
        chk("R10 ratio", tmds_ratio, 1);
        chk("R10 scramble", scramble_en, 1);
        chk("R10 ratio strobes", ratio_cnt, 1);
        chk("R10 scramble strobes", scr_cnt, 1);
        chk("R10 same-cycle strobes", both_cnt, 1);
        for (int k = 0; k < 2; k++) begin
            bus_start();
            put_byte(8'hA8, a);
            put_byte(8'h20, a);
            put_byte(8'h02, a);
            bus_stop(); hw(5);
        end
        chk("R10 scramble cleared", scramble_en, 0);
        chk("R10 ratio held", tmds_ratio, 1);
        chk("R10 scramble strobes once more", scr_cnt, 2);
        chk("R10 ratio no strobe", ratio_cnt, 1);
    endtask

    task automatic t_ctrl_read();
        logic a; logic [7:0] d;
        bus_start();
        put_byte(8'hA8, a);
        put_byte(8'h1E, a);
        bus_start();
        put_byte(8'hA9, a); chk("R2 ack A9", a, 1);
        get_byte(1'b1, d); chk("R12 reg 1E", d, 8'h11);
        get_byte(1'b0, d); chk("R12 reg 1F", d, 8'h22);
        bus_stop();
    endtask

    task automatic t_cap_write();
        logic a; logic [7:0] d;
        int base = wr_cnt;
        bus_start();
        put_byte(8'hA0, a);
        put_byte(8'h05, a);
        put_byte(8'h77, a); chk("R8 ack cap data", a, 1);
        bus_stop(); hw(5);
        chk("R8 no reg write", wr_cnt - base, 0);
        bus_start();
        put_byte(8'hA1, a);
        get_byte(1'b0, d); chk("R8 pointer advanced", d, cap_f(8'h06));
        bus_stop();
    endtask

    initial begin
        hw(5);
        rst = 1'b0;
        hw(5);
        t_reset();
        t_cap_read();
        t_continue();
        t_bad_addr();
        t_ctrl_write();
        t_ctrl_read();
        t_cap_write();
        chk("R11 oe change with scl high", viol, 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1 actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule